// File: doc/BRIEF.md
# Cascadable Synchronous Up-Counter

This block is a chain of identical four-bit up-counter slices that behave as one wide binary counter. Every bit of every slice moves on the same rising clock edge, so no bit ripples from another. Each slice can be cleared to zero or loaded from parallel data. It advances only when two separate enables are both high. Each slice also drives a lookahead carry. That carry is built from the second enable and the slice being at its all-ones value.

The wrapper chains the slices. The carry of each slice feeds the second enable of the slice above it. The first enable of every slice comes from one shared global enable. The result is a wide synchronous counter that needs no gating between stages. Clear, load, clock and reset are common to all slices. Clear wins over load, and load wins over counting. The top-level carry goes high while the whole counter holds its maximum value and the chain enable is high, so two such counters can be chained in the same way.

Top module: `ctr_cascade`

## Requirements
- R1: While `rst` is high at a rising edge, every counter bit is zero after that edge.
- R2: With `rst` low, a low `clr_n` at a rising edge forces `q` to zero after that edge, whatever `load_n`, the enables and `din` are.
- R3: With `rst` low and `clr_n` high, a low `load_n` at a rising edge copies `din` onto `q` after that edge, and no count happens in that cycle.
- R4: With `clr_n` and `load_n` both high, `q` changes only when `en_p` and `en_t` are both high; if either is low, `q` keeps its value.
- R5: When counting from the all-ones value, the counter wraps to zero.
- R6: `carry_out` is combinational and equals `en_t` AND (`q` all ones), so it changes in the same cycle as its inputs.
- R7: While counting, `q` increases by exactly one per edge as a single binary number; bit 0 is the least significant bit, and bits [4k+3:4k] belong to slice k.
- R8: A low `en_t` blocks counting in every slice and holds `carry_out` low, even when `en_p` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| rst | input | 1 | Synchronous active-high reset to zero |
| clr_n | input | 1 | Synchronous active-low clear, highest priority after reset |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Global count enable, fed to every slice |
| en_t | input | 1 | Chain enable into the lowest slice; it also gates the carry |
| din | input | 12 | Parallel load data |
| q | output | 12 | Counter value, binary weighted |
| carry_out | output | 1 | Lookahead carry of the top slice |

## Verification
`q` changes one edge after the control inputs are sampled. `carry_out` follows `en_t` and `q` within the same cycle. The bench therefore drives its inputs just after a falling edge. It checks `carry_out` against the newly applied `en_t` a moment later, still before the rising edge. It checks `q` one time step after the rising edge against a 12-bit reference. That reference is updated with the inputs that were in place at that edge. The sweeps count through all 4096 values, force every priority combination, and then run 5000 random cycles with every output compared on every cycle.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } slice_ctrl_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } slice_op_t;

    // Clear over load over count; anything else holds.
    function automatic slice_op_t decode_op(slice_ctrl_t c);
        if (!c.clr_n)             return OP_CLEAR;
        else if (!c.load_n)       return OP_LOAD;
        else if (c.en_p && c.en_t) return OP_COUNT;
        else                      return OP_HOLD;
    endfunction

    function automatic logic digit_full(digit_t v);
        return &v;
    endfunction

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import ctr_pkg::*;
(
    input  slice_ctrl_t ctrl,
    input  digit_t      cur,
    input  digit_t      load_val,
    output digit_t      nxt,
    output logic        carry
);
    slice_op_t op;

    always_comb begin
        op = decode_op(ctrl);
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = load_val;
            OP_COUNT: nxt = cur + digit_t'(1);
            default:  nxt = cur;
        endcase
    end

    // Lookahead carry: only the chain enable is fed forward.
    assign carry = ctrl.en_t & digit_full(cur);

endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  slice_ctrl_t ctrl,
    input  digit_t      d,
    output digit_t      q,
    output logic        co
);
    digit_t nxt;

    ctr_op_decode i_dec (
        .ctrl     (ctrl),
        .cur      (q),
        .load_val (d),
        .nxt      (nxt),
        .carry    (co)
    );

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assert_reset_R1: assert property (@(posedge clk) rst |=> (q == '0));

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        !ctrl.clr_n |=> (q == '0));

    assert_load_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr_n && !ctrl.load_n) |=> (q == $past(d)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr_n && ctrl.load_n && !(ctrl.en_p && ctrl.en_t)) |=> $stable(q));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.clr_n && ctrl.load_n && ctrl.en_p && ctrl.en_t && digit_full(q))
        |=> (q == '0));

    assert_carry_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en_t |-> !co);

endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade
    import ctr_pkg::*;
#(
    parameter int N_SLICES = 3,
    localparam int TOTAL_W = N_SLICES * DIGIT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [TOTAL_W-1:0] din,
    output logic [TOTAL_W-1:0] q,
    output logic               carry_out
);
    logic [N_SLICES:0] t_chain;

    assign t_chain[0] = en_t;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        slice_ctrl_t ctrl;
        digit_t      qs;

        assign ctrl = '{clr_n: clr_n, load_n: load_n, en_p: en_p, en_t: t_chain[k]};

        ctr_slice i_slice (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl),
            .d    (din[k*DIGIT_W +: DIGIT_W]),
            .q    (qs),
            .co   (t_chain[k+1])
        );

        assign q[k*DIGIT_W +: DIGIT_W] = qs;
    end

    assign carry_out = t_chain[N_SLICES];

    assert_count_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && en_p && en_t) |=> (q == TOTAL_W'($past(q) + 1'b1)));

    assert_carry_R6: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (en_t && (&q)));

    assert_block_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_n && load_n && !en_t) |=> $stable(q));

endmodule

// File: tb/test_ctr_cascade.sv
module test_ctr_cascade;
    localparam int W = 12;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst, clr_n, load_n, en_p, en_t;
    logic [W-1:0] din, q;
    logic         carry_out;
    logic [W-1:0] ref_q;
    int           total = 0;
    int           bad = 0;

    always #2 clk = ~clk;

    ctr_cascade i_ctr_cascade (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n),
        .en_p(en_p), .en_t(en_t), .din(din), .q(q), .carry_out(carry_out)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply inputs after a falling edge, check carry before the rising edge,
    // then check q just after the rising edge.
    task automatic step(input logic r, input logic c, input logic l, input logic p,
                        input logic t, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        rst = r; clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
        #1;
        if (!r) check(carry_out == (t && ref_q == MAXV), {tag, " R6 carry"},
                      W'(carry_out), W'(t && ref_q == MAXV));
        if (r)           ref_q = '0;
        else if (!c)     ref_q = '0;
        else if (!l)     ref_q = d;
        else if (p && t) ref_q = ref_q + 1'b1;
        @(posedge clk);
        #1;
        check(q == ref_q, tag, q, ref_q);
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1; clr_n = 1; load_n = 1; en_p = 0; en_t = 0; din = '0; ref_q = '0;
        step(1, 1, 1, 1, 1, 12'hABC, "R1 reset");
        step(1, 0, 0, 1, 1, 12'h123, "R1 reset over load");
        // Full sweep: every value and every slice carry, ending in a wrap.
        for (int i = 0; i < 4097; i++) step(0, 1, 1, 1, 1, '0, "R7 count");
        check(q == 12'd1, "R5 wrap", q, 12'd1);
        // Load and priority
        step(0, 1, 0, 1, 1, 12'h5A3, "R3 load");
        step(0, 1, 0, 1, 1, 12'h5A3, "R3 load no count");
        step(0, 0, 0, 1, 1, 12'h777, "R2 clear over load");
        step(0, 1, 0, 0, 0, 12'hFFE, "R3 load max-1");
        step(0, 1, 1, 1, 1, '0, "R7 to max");
        step(0, 1, 1, 0, 1, '0, "R4 hold p low at max");
        step(0, 1, 1, 1, 0, '0, "R8 hold t low at max");
        step(0, 1, 1, 1, 1, '0, "R5 wrap from max");
        step(0, 1, 0, 1, 1, 12'h0FF, "R3 load low slices full");
        step(0, 1, 1, 1, 0, '0, "R8 no carry into upper");
        step(0, 1, 1, 1, 1, '0, "R7 ripple-free carry");
        step(0, 0, 1, 1, 1, '0, "R2 clear over count");
        for (int i = 0; i < 5000; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0] & rv[1] & rv[2] & rv[3], ~(rv[4] & rv[5] & rv[6]),
                 ~(rv[7] & rv[8] & rv[9]), rv[10] | rv[11], rv[12] | rv[13] | rv[14],
                 W'(rv[31:20]), "R4 R7 random");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule